// File: doc/BRIEF.md
# Sleep Entry and Wake Sequencer

This block runs in the always-on slow (32 kHz) clock domain of a small microcontroller. It sequences the chip into and out of a low-power sleep state. Firmware asks for sleep with a one-cycle write strobe that sets the sleep bit. The sequencer then waits until the CPU reports an instruction boundary and halts the core there. In the same cycle it drops the enables for the fast oscillator, the flash module and the voltage reference. The slow clock, the logic on that clock and the supply monitor are never switched by this block.

While asleep, a timer in the slow domain requests a one-cycle reference refresh at a fixed period. This keeps the reference voltage from drifting. Reset is one way out of sleep. The other is any enabled interrupt, seen after a two-flop synchronizer. On wake the fast oscillator is switched on first and given a fixed settling window. After that window the flash, the reference and the CPU are released together, and the sleep bit clears. A sleep request made while an enabled interrupt is already pending is dropped, and the CPU keeps running.

Top module: `sleep_seq_top`

## Requirements
- R1: After reset, sleep_bit=0, cpu_halt=0, fosc_en=1, flash_en=1, vref_en=1 and vref_refresh=0.
- R2: A sleep_set strobe with no enabled interrupt pending raises sleep_bit on the next clock edge. cpu_halt stays 0 until insn_boundary is seen.
- R3: When insn_boundary is high while the block waits for a boundary, cpu_halt rises on the next edge. On that same edge fosc_en, flash_en and vref_en fall.
- R4: A sleep_set strobe in the running state while an enabled interrupt is pending is ignored: sleep_bit stays 0 and cpu_halt stays 0.
- R5: An interrupt wakes the block only if its irq_en bit is 1. Any irq_raw change takes effect through two synchronizing flops. A raw rise therefore moves the state on the third clock edge after it.
- R6: While asleep, vref_refresh is high for exactly one cycle at a time. The first pulse comes in the REFRESH_PERIOD-th sleep cycle (default 256), and pulses repeat every REFRESH_PERIOD cycles. vref_en is high during each pulse.
- R7: On a wake, fosc_en rises first while flash_en=0 and cpu_halt=1, for SETTLE_CYC cycles (default 16). After that, flash_en=1, vref_en=1, cpu_halt=0 and sleep_bit=0 on the same edge.
- R8: If an enabled interrupt becomes pending while the block waits for an instruction boundary, the request is abandoned. sleep_bit returns to 0 without halting, and the pending interrupt takes priority over a boundary in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_set | input | 1 | One-cycle firmware write strobe setting the sleep bit |
| insn_boundary | input | 1 | CPU is at an instruction boundary |
| irq_raw | input | N_IRQ | Asynchronous interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| sleep_bit | output | 1 | Sleep bit as seen by firmware |
| cpu_halt | output | 1 | Halt request to the CPU core |
| fosc_en | output | 1 | Fast oscillator enable |
| flash_en | output | 1 | Flash module power enable |
| vref_en | output | 1 | Voltage reference enable |
| vref_refresh | output | 1 | One-cycle reference refresh pulse during sleep |

## Verification
Every output is a decode of registered state, so each result appears on the first clock edge after its cause:
- sleep_bit follows sleep_set by one edge.
- cpu_halt and the power drop follow insn_boundary by one edge.
- A wake follows a raw interrupt rise by three edges: two synchronizer flops, then the state register.
- The flash and CPU are released SETTLE_CYC edges after the oscillator comes on.

The bench drives inputs on the falling edge. A behavioural model updates on the rising edge, and all six outputs are compared with that model on every falling edge. Each result is therefore checked in exactly the cycle it is due. Counts of refresh pulses and of the settling window are checked explicitly on top of the per-cycle comparison.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_WAIT   = 2'd1,
    PH_ASLEEP = 2'd2,
    PH_SETTLE = 2'd3
  } phase_t;
endpackage

// File: rtl/sleep_rst_sync.sv
module sleep_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign rst_n_out = stg2_q;
endmodule

// File: rtl/sleep_irq_sync.sv
module sleep_irq_sync #(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_raw,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             irq_pend
);
  logic [N_IRQ-1:0] meta_q, sync_q;

  for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[gi] <= 1'b0;
        sync_q[gi] <= 1'b0;
      end else begin
        meta_q[gi] <= irq_raw[gi];
        sync_q[gi] <= meta_q[gi];
      end
    end
  end

  assign irq_pend = |(sync_q & irq_en);
endmodule

// File: rtl/sleep_refresh_timer.sv
module sleep_refresh_timer #(
  parameter int REFRESH_PERIOD = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic pulse
);
  localparam int CW = (REFRESH_PERIOD > 1) ? $clog2(REFRESH_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFRESH_PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!active)
      cnt_d = '0;
    else if (at_last)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse = active && at_last;
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sleep_set,
  input  logic   insn_boundary,
  input  logic   irq_pend,
  output phase_t phase
);
  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SW-1:0] SLAST = SW'(SETTLE_CYC - 1);

  phase_t        ph_q, ph_d;
  logic [SW-1:0] st_q, st_d;
  logic          st_en;

  always_comb begin
    ph_d  = ph_q;
    st_d  = st_q;
    st_en = 1'b0;
    unique case (ph_q)
      PH_RUN: begin
        if (sleep_set && !irq_pend) ph_d = PH_WAIT;
      end
      PH_WAIT: begin
        if (irq_pend)           ph_d = PH_RUN;
        else if (insn_boundary) ph_d = PH_ASLEEP;
      end
      PH_ASLEEP: begin
        if (irq_pend) begin
          ph_d  = PH_SETTLE;
          st_d  = '0;
          st_en = 1'b1;
        end
      end
      PH_SETTLE: begin
        st_en = 1'b1;
        if (st_q == SLAST) begin
          ph_d = PH_RUN;
          st_d = '0;
        end else begin
          st_d = st_q + 1'b1;
        end
      end
      default: ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_RUN;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign phase = ph_q;
endmodule

// File: rtl/sleep_seq_top.sv
module sleep_seq_top
  import sleep_seq_pkg::*;
#(
  parameter int N_IRQ          = 4,
  parameter int SETTLE_CYC     = 16,
  parameter int REFRESH_PERIOD = 256
) (
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic             sleep_set,
  input  logic             insn_boundary,
  input  logic [N_IRQ-1:0] irq_raw,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             sleep_bit,
  output logic             cpu_halt,
  output logic             fosc_en,
  output logic             flash_en,
  output logic             vref_en,
  output logic             vref_refresh
);
  logic   rst_n_int;
  logic   irq_pend;
  logic   refresh;
  phase_t phase;

  sleep_rst_sync u_rst (
    .clk       (clk_slow),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  sleep_irq_sync #(.N_IRQ(N_IRQ)) u_irq (
    .clk      (clk_slow),
    .rst_n    (rst_n_int),
    .irq_raw  (irq_raw),
    .irq_en   (irq_en),
    .irq_pend (irq_pend)
  );

  sleep_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk           (clk_slow),
    .rst_n         (rst_n_int),
    .sleep_set     (sleep_set),
    .insn_boundary (insn_boundary),
    .irq_pend      (irq_pend),
    .phase         (phase)
  );

  sleep_refresh_timer #(.REFRESH_PERIOD(REFRESH_PERIOD)) u_ref (
    .clk    (clk_slow),
    .rst_n  (rst_n_int),
    .active (phase == PH_ASLEEP),
    .pulse  (refresh)
  );

  assign sleep_bit    = (phase != PH_RUN);
  assign cpu_halt     = (phase == PH_ASLEEP) || (phase == PH_SETTLE);
  assign fosc_en      = (phase != PH_ASLEEP);
  assign flash_en     = (phase == PH_RUN) || (phase == PH_WAIT);
  assign vref_en      = flash_en || refresh;
  assign vref_refresh = refresh;
endmodule

// File: rtl/sleep_seq_checker.sv
module sleep_seq_checker (
  input logic clk_slow,
  input logic rst_n,
  input logic sleep_set,
  input logic insn_boundary,
  input logic irq_pend,
  input logic sleep_bit,
  input logic cpu_halt,
  input logic fosc_en,
  input logic flash_en,
  input logic vref_refresh
);
  AST_HALT_AT_BOUNDARY: assert property (@(posedge clk_slow) disable iff (!rst_n)
    $rose(cpu_halt) |-> $past(insn_boundary)); // R3

  AST_DOMAINS_OFF_TOGETHER: assert property (@(posedge clk_slow) disable iff (!rst_n)
    !fosc_en |-> (cpu_halt && !flash_en && sleep_bit)); // R3

  AST_IGNORE_WHEN_PENDING: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (!sleep_bit && sleep_set && irq_pend) |=> !sleep_bit); // R4

  AST_WAKE_BY_IRQ_ONLY: assert property (@(posedge clk_slow) disable iff (!rst_n)
    $rose(fosc_en) |-> $past(irq_pend)); // R5

  AST_REFRESH_SINGLE: assert property (@(posedge clk_slow) disable iff (!rst_n)
    vref_refresh |=> !vref_refresh); // R6

  AST_REFRESH_ASLEEP: assert property (@(posedge clk_slow) disable iff (!rst_n)
    vref_refresh |-> (!fosc_en && cpu_halt)); // R6

  AST_FLASH_AFTER_FOSC: assert property (@(posedge clk_slow) disable iff (!rst_n)
    $rose(flash_en) |-> ($past(fosc_en) && !cpu_halt && !sleep_bit)); // R7
endmodule

bind sleep_seq_top sleep_seq_checker u_chk (
  .clk_slow      (clk_slow),
  .rst_n         (rst_n),
  .sleep_set     (sleep_set),
  .insn_boundary (insn_boundary),
  .irq_pend      (irq_pend),
  .sleep_bit     (sleep_bit),
  .cpu_halt      (cpu_halt),
  .fosc_en       (fosc_en),
  .flash_en      (flash_en),
  .vref_refresh  (vref_refresh)
);

// File: tb/sleep_seq_top_bench.sv
`timescale 1ns/1ps
module sleep_seq_top_bench;
  localparam int NI  = 4;
  localparam int SET = 16;
  localparam int PER = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_set = 1'b0;
  logic          insn_boundary = 1'b0;
  logic [NI-1:0] irq_raw = '0;
  logic [NI-1:0] irq_en = '0;
  logic          sleep_bit, cpu_halt, fosc_en, flash_en, vref_en, vref_refresh;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  sleep_seq_top #(.N_IRQ(NI), .SETTLE_CYC(SET), .REFRESH_PERIOD(PER)) u_sleep_seq_top (
    .clk_slow      (clk),
    .rst_n         (rst_n),
    .sleep_set     (sleep_set),
    .insn_boundary (insn_boundary),
    .irq_raw       (irq_raw),
    .irq_en        (irq_en),
    .sleep_bit     (sleep_bit),
    .cpu_halt      (cpu_halt),
    .fosc_en       (fosc_en),
    .flash_en      (flash_en),
    .vref_en       (vref_en),
    .vref_refresh  (vref_refresh)
  );

  // behavioural reference: 0 run, 1 waiting, 2 asleep, 3 settling
  int            m_ph = 0;
  int            m_settle = 0;
  int            m_idx = 0;
  logic [NI-1:0] m_s1 = '0;
  logic [NI-1:0] m_s2 = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_settle = 0; m_idx = 0; m_s1 = '0; m_s2 = '0;
    end else begin
      automatic bit pend = |(m_s2 & irq_en);
      automatic int nx = m_ph;
      case (m_ph)
        0: if (sleep_set && !pend) nx = 1;
        1: if (pend) nx = 0; else if (insn_boundary) nx = 2;
        2: if (pend) begin nx = 3; m_settle = 0; end
        default: begin
          if (m_settle == SET - 1) nx = 0;
          else m_settle++;
        end
      endcase
      if (m_ph == 2 && nx == 2) m_idx++;
      else m_idx = 0;
      m_ph = nx;
      m_s2 = m_s1;
      m_s1 = irq_raw;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      automatic logic e_ref = (m_ph == 2) && (m_idx % PER == PER - 1);
      automatic logic e_fl  = (m_ph < 2);
      chk("R2 sleep_bit",    sleep_bit,    m_ph != 0);
      chk("R3 cpu_halt",     cpu_halt,     m_ph >= 2);
      chk("R7 fosc_en",      fosc_en,      m_ph != 2);
      chk("R7 flash_en",     flash_en,     e_fl);
      chk("R6 vref_en",      vref_en,      e_fl | e_ref);
      chk("R6 vref_refresh", vref_refresh, e_ref);
      if (vref_refresh) pulses++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe_sleep();
    @(negedge clk); sleep_set = 1'b1;
    @(negedge clk); sleep_set = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 sleep_bit", sleep_bit, 1'b0);
    chk("R1 cpu_halt",  cpu_halt,  1'b0);
    chk("R1 fosc_en",   fosc_en,   1'b1);
    chk("R1 flash_en",  flash_en,  1'b1);
    chk("R1 vref_en",   vref_en,   1'b1);
    chk("R1 refresh",   vref_refresh, 1'b0);

    // R2: bit set, no halt until boundary
    irq_en = 4'b0011;
    strobe_sleep();
    chk("R2 bit set after strobe", sleep_bit, 1'b1);
    idle(5);
    chk("R2 no halt before boundary", cpu_halt, 1'b0);
    // R3 halt one edge after boundary
    insn_boundary = 1'b1;
    @(negedge clk); insn_boundary = 1'b0;
    chk("R3 halted", cpu_halt, 1'b1);
    chk("R3 fosc off", fosc_en, 1'b0);
    chk("R3 vref off", vref_en, 1'b0);

    // R6 refresh pulses over 600 sleep cycles
    pulses = 0;
    idle(599);
    chk("R6 two pulses in 600 cycles", pulses == 2, 1'b1);

    // R5 disabled line does not wake
    irq_raw = 4'b0100;
    idle(10);
    chk("R5 disabled irq keeps sleep", fosc_en, 1'b0);
    irq_raw = 4'b0000;
    idle(3);

    // R5/R7 enabled line wakes after three edges, then settles
    irq_raw = 4'b0010;
    idle(2);
    chk("R5 not yet awake at edge 2", fosc_en, 1'b0);
    idle(1);
    chk("R5 fosc on at edge 3", fosc_en, 1'b1);
    chk("R7 flash held off", flash_en, 1'b0);
    irq_raw = 4'b0000;
    idle(SET - 1);
    chk("R7 still settling", cpu_halt, 1'b1);
    idle(1);
    chk("R7 cpu released", cpu_halt, 1'b0);
    chk("R7 flash on", flash_en, 1'b1);
    chk("R7 bit cleared", sleep_bit, 1'b0);
    idle(4);

    // R4 request ignored while pending
    irq_raw = 4'b0001;
    idle(3);
    strobe_sleep();
    chk("R4 ignored bit", sleep_bit, 1'b0);
    idle(3);
    chk("R4 ignored halt", cpu_halt, 1'b0);
    irq_raw = 4'b0000;
    idle(4);

    // R8 abort while waiting, irq beats boundary
    strobe_sleep();
    chk("R8 waiting", sleep_bit, 1'b1);
    irq_raw = 4'b0010;
    idle(2);
    insn_boundary = 1'b1;
    @(negedge clk); insn_boundary = 1'b0;
    chk("R8 aborted bit", sleep_bit, 1'b0);
    chk("R8 no halt", cpu_halt, 1'b0);
    irq_raw = 4'b0000;
    idle(5);

    // second sleep with different line, immediate boundary
    irq_en = 4'b1000;
    @(negedge clk); sleep_set = 1'b1; insn_boundary = 1'b1;
    @(negedge clk); sleep_set = 1'b0;
    @(negedge clk); insn_boundary = 1'b0;
    chk("R3 halted second", cpu_halt, 1'b1);
    irq_raw = 4'b1000;
    idle(3 + SET + 2);
    chk("R7 awake second", flash_en, 1'b1);
    irq_raw = 4'b0000;
    idle(5);
    summary();
  end
endmodule